// File: doc/BRIEF.md
# PRBS and Fixed-Pattern Receive Checker

This block checks a parallel word stream against a known test pattern and measures how many bits arrived wrong. The pattern is chosen by the same selection registers that drive the matching transmit generator. It can be a pseudo-random sequence of order 7, 9, 11, 13, 23, 31 or 58, sent as plain binary (NRZ) or as Gray-mapped four-level symbols (PAM4). It can also be a user-supplied reference word of 32, 64 or 128 bits, or a square wave whose runs are 1, 8 or 64 bits long. Bit 0 of each word is the earliest bit on the line.

For the pseudo-random patterns the checker does not need to be told the generator's seed. While unlocked it copies the most recent received bits into its own shift history and predicts each next word from them. Once locked it runs free on its own predictions, so one corrupted bit is counted once and is not spread into later words. For the fixed patterns it searches the word phases of the 128-bit reference for one that matches exactly. The block reports a lock flag and a saturating count of bit errors. Software can clear the count at any time.

The word input is a valid/ready stream. `rx_ready` is always high, because the checker never pushes back. A word is consumed on every clock edge where `rx_valid` is high. Cycles with `rx_valid` low are idle and change nothing. The selection inputs are treated as static and may change only while `rst` is held. `W` must be a power of two from 8 to 32. This keeps both PAM4 symbol pairs and the 128-bit reference phases whole.

Top module: `prbs_verifier`

## Requirements
- R1: While `rst` (synchronous, active high) is held and on the first edge after it, `locked` is 0 and `err_count` is 0. `rx_ready` is 1 at all times.
- R2: `pat_sel` codes 0 to 6 select pseudo-random orders 7, 9, 11, 13, 23, 31 and 58. The recurrences are b[n]=b[n-7]^b[n-6], b[n-9]^b[n-5], b[n-11]^b[n-9], b[n-13]^b[n-12]^b[n-2]^b[n-1], b[n-23]^b[n-18], b[n-31]^b[n-28] and b[n-58]^b[n-39]. While unlocked, the predictor history is loaded from received bits. `locked` rises on the edge that accepts the 4th consecutive valid word with no errors.
- R3: With `pam4_en`=1 in a pseudo-random mode, each bit pair (2k, 2k+1) of the line word carries sequence bits (p0, p1) as line bits (p0, p1^p0). The checker undoes this mapping before seeding and applies it to its prediction.
- R4: The per-word error count is the number of 1 bits in (received XOR expected line word). It is added to `err_count` only on edges where `rx_valid` and `locked` are both 1. While locked, the predictor advances on its own prediction, so a corrupted word adds its own flips only.
- R5: While locked, a word whose error count is greater than `err_thresh` is bad. The 4th consecutive bad valid word clears `locked`, and its errors are still counted. After that the checker reseeds from the data and can lock again.
- R6: `pat_sel`=7 checks `user_word` repeated with period 32, 64 or 128 bits for `user_len` 0, 1 or 2. Word p of the 128-bit reference is bits [p*W +: W]. Checking starts at phase 0, so a stream aligned to phase 0 locks after 4 words.
- R7: `pat_sel`=8 to 15 checks a square wave whose bit j is (j / R) mod 2, with R = 1, 8 or 64 for `alt_run` 0, 1 or 2. While unlocked, a miss moves the phase to just past the lowest reference word that equals the received word.
- R8: `err_count` stops at all ones (CNT_W bits wide, 32 by default) instead of wrapping.
- R9: `cnt_clr` zeroes `err_count` on the next edge and takes priority over any addition in that cycle.
- R10: A cycle with `rx_valid` low changes neither `locked` nor `err_count`, whatever `rx_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | W | Received word, bit 0 earliest |
| rx_valid | input | 1 | Word on `rx_data` is present this cycle |
| rx_ready | output | 1 | Always 1; the checker accepts every word |
| pat_sel | input | 4 | Pattern select (0-6 pseudo-random, 7 user word, 8-15 square wave) |
| pam4_en | input | 1 | Gray-mapped four-level form for pseudo-random modes |
| user_word | input | 128 | Reference word for user mode |
| user_len | input | 2 | User word length: 0=32, 1=64, 2/3=128 bits |
| alt_run | input | 2 | Square-wave run: 0=1, 1=8, 2/3=64 bits |
| err_thresh | input | $clog2(W+1) | Per-word error count above which a word is bad |
| cnt_clr | input | 1 | Synchronous clear of the error count |
| locked | output | 1 | Checker is aligned to the pattern |
| err_count | output | CNT_W | Saturating total of bit errors |

## Verification
Two functions can meet on the same edge. The clear can arrive in the same cycle as a counted, error-carrying word, and the bench drives exactly that: a word with five flipped bits together with `cnt_clr`. Clear must win and leave zero, and the next corrupted word must then count alone. A second meeting point is the word that drops the lock. It is both the 4th bad word and a counted word, so the bench checks that the lock falls on that edge and that all of its flips are still in the total.

// File: rtl/prbs_vrf_pkg.sv
`timescale 1ns/1ps
package prbs_vrf_pkg;
  localparam int HIST_W = 58;
  localparam int REF_W  = 128;

  localparam logic [3:0] SEL_P7   = 4'd0;
  localparam logic [3:0] SEL_P9   = 4'd1;
  localparam logic [3:0] SEL_P11  = 4'd2;
  localparam logic [3:0] SEL_P13  = 4'd3;
  localparam logic [3:0] SEL_P23  = 4'd4;
  localparam logic [3:0] SEL_P31  = 4'd5;
  localparam logic [3:0] SEL_P58  = 4'd6;
  localparam logic [3:0] SEL_USER = 4'd7;

  typedef struct packed {
    logic [5:0] ta;
    logic [5:0] tb;
    logic [5:0] tc;
    logic [5:0] td;
    logic       quad;
  } taps_t;

  function automatic taps_t taps_for(input logic [3:0] sel);
    taps_t t;
    t = '{ta: 6'd7, tb: 6'd6, tc: 6'd0, td: 6'd0, quad: 1'b0};
    case (sel)
      SEL_P9:  begin t.ta = 6'd9;  t.tb = 6'd5;  end
      SEL_P11: begin t.ta = 6'd11; t.tb = 6'd9;  end
      SEL_P13: begin t.ta = 6'd13; t.tb = 6'd12; t.tc = 6'd2; t.td = 6'd1; t.quad = 1'b1; end
      SEL_P23: begin t.ta = 6'd23; t.tb = 6'd18; end
      SEL_P31: begin t.ta = 6'd31; t.tb = 6'd28; end
      SEL_P58: begin t.ta = 6'd58; t.tb = 6'd39; end
      default: ;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/prbs_pred.sv
`timescale 1ns/1ps
module prbs_pred import prbs_vrf_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         seed,
  input  logic         pam4,
  input  taps_t        taps,
  input  logic [W-1:0] rx,
  output logic [W-1:0] exp_line
);
  localparam int CAT_W = HIST_W + W;

  logic [HIST_W-1:0] hist;
  logic [W-1:0]      pred, rx_seq;
  logic [CAT_W-1:0]  cat_s;

  // Extend the history bit by bit; later bits of the word see earlier ones.
  always_comb begin
    logic [CAT_W-1:0] e;
    e = '0;
    e[HIST_W-1:0] = hist;
    for (int i = 0; i < W; i++) begin
      logic b;
      b = e[HIST_W + i - int'(taps.ta)] ^ e[HIST_W + i - int'(taps.tb)];
      if (taps.quad)
        b = b ^ e[HIST_W + i - int'(taps.tc)] ^ e[HIST_W + i - int'(taps.td)];
      e[HIST_W + i] = b;
    end
    pred = e[HIST_W +: W];
  end

  // Four-level Gray mapping per bit pair; it is its own inverse.
  for (genvar k = 0; k < W / 2; k++) begin : g_pair
    assign rx_seq[2*k]     = rx[2*k];
    assign rx_seq[2*k+1]   = rx[2*k+1] ^ (pam4 & rx[2*k]);
    assign exp_line[2*k]   = pred[2*k];
    assign exp_line[2*k+1] = pred[2*k+1] ^ (pam4 & pred[2*k]);
  end

  assign cat_s = seed ? {rx_seq, hist} : {pred, hist};

  always_ff @(posedge clk) begin
    if (rst)      hist <= '0;
    else if (adv) hist <= cat_s[CAT_W-1 -: HIST_W];
  end
endmodule

// File: rtl/pat_align.sv
`timescale 1ns/1ps
module pat_align import prbs_vrf_pkg::*; #(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             locked,
  input  logic             user_mode,
  input  logic [REF_W-1:0] user_word,
  input  logic [1:0]       user_len,
  input  logic [1:0]       alt_run,
  input  logic [W-1:0]     rx,
  output logic [W-1:0]     exp_word,
  output logic             hit
);
  localparam int NP = REF_W / W;
  localparam int PW = $clog2(NP);

  logic [REF_W-1:0] ref_pat;
  logic [W-1:0]     cand [NP];
  logic [PW-1:0]    phase, first_m;
  logic             any_m;

  always_comb begin
    for (int j = 0; j < REF_W; j++) begin
      if (user_mode) begin
        case (user_len)
          2'd0:    ref_pat[j] = user_word[j % 32];
          2'd1:    ref_pat[j] = user_word[j % 64];
          default: ref_pat[j] = user_word[j];
        endcase
      end else begin
        case (alt_run)
          2'd0:    ref_pat[j] = j[0];
          2'd1:    ref_pat[j] = j[3];
          default: ref_pat[j] = j[6];
        endcase
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_cand
    assign cand[p] = ref_pat[p*W +: W];
  end

  assign exp_word = cand[phase];
  assign hit      = (rx == exp_word);

  // Lowest matching phase wins.
  always_comb begin
    any_m   = 1'b0;
    first_m = '0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (cand[p] == rx) begin
        any_m   = 1'b1;
        first_m = PW'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (adv) begin
      if (locked || hit || !any_m) phase <= phase + 1'b1;
      else                         phase <= first_m + 1'b1;
    end
  end

  // R7
  jump_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !locked && !hit && any_m) |=> (phase != $past(phase) + 1'b1) || ($past(first_m) == $past(phase)));
endmodule

// File: rtl/lock_ctl.sv
`timescale 1ns/1ps
module lock_ctl #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic ok,
  input  logic bad,
  output logic locked
);
  localparam int RW = $clog2(RUN + 1);

  logic [RW-1:0] good_n, bad_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      good_n <= '0;
      bad_n  <= '0;
    end else if (adv) begin
      if (!locked) begin
        bad_n <= '0;
        if (!ok)                          good_n <= '0;
        else if (good_n == RW'(RUN - 1)) begin locked <= 1'b1; good_n <= '0; end
        else                              good_n <= good_n + 1'b1;
      end else begin
        good_n <= '0;
        if (!bad)                         bad_n <= '0;
        else if (bad_n == RW'(RUN - 1))  begin locked <= 1'b0; bad_n <= '0; end
        else                              bad_n <= bad_n + 1'b1;
      end
    end
  end

  // R2
  stay_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && !(adv && ok)) |=> !locked);
  // R5
  stay_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !(adv && bad)) |=> locked);
  // R10
  idle_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(locked));
endmodule

// File: rtl/err_acc.sv
`timescale 1ns/1ps
module err_acc #(
  parameter int EW = 6,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add_en,
  input  logic [EW-1:0] nerr,
  output logic [CW-1:0] count
);
  logic [CW:0] sum;
  assign sum = {1'b0, count} + (CW+1)'(nerr);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (add_en) count <= sum[CW] ? '1 : sum[CW-1:0];
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count >= $past(count)));
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((&count) && !clr) |=> (&count));
  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !add_en) |=> $stable(count));
endmodule

// File: rtl/prbs_verifier.sv
`timescale 1ns/1ps
module prbs_verifier import prbs_vrf_pkg::*; #(
  parameter  int W        = 32,
  parameter  int CNT_W    = 32,
  parameter  int LOCK_RUN = 4,
  localparam int EW       = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [3:0]       pat_sel,
  input  logic             pam4_en,
  input  logic [REF_W-1:0] user_word,
  input  logic [1:0]       user_len,
  input  logic [1:0]       alt_run,
  input  logic [EW-1:0]    err_thresh,
  input  logic             cnt_clr,
  output logic             locked,
  output logic [CNT_W-1:0] err_count
);
  logic         prbs_mode, user_mode, pat_hit, word_ok, word_bad;
  logic [W-1:0] prbs_exp, pat_exp, exp_word, diff;
  logic [EW-1:0] nerr;
  taps_t        taps;

  assign rx_ready  = 1'b1;
  assign prbs_mode = (pat_sel < SEL_USER);
  assign user_mode = (pat_sel == SEL_USER);
  assign taps      = taps_for(pat_sel);

  prbs_pred #(.W(W)) u_pred (
    .clk(clk), .rst(rst), .adv(rx_valid), .seed(!locked), .pam4(pam4_en),
    .taps(taps), .rx(rx_data), .exp_line(prbs_exp)
  );

  pat_align #(.W(W)) u_align (
    .clk(clk), .rst(rst), .adv(rx_valid), .locked(locked), .user_mode(user_mode),
    .user_word(user_word), .user_len(user_len), .alt_run(alt_run),
    .rx(rx_data), .exp_word(pat_exp), .hit(pat_hit)
  );

  assign exp_word = prbs_mode ? prbs_exp : pat_exp;
  assign diff     = rx_data ^ exp_word;

  always_comb begin
    nerr = '0;
    for (int i = 0; i < W; i++) nerr = nerr + EW'(diff[i]);
  end

  assign word_ok  = prbs_mode ? (nerr == '0) : pat_hit;
  assign word_bad = (nerr > err_thresh);

  lock_ctl #(.RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst(rst), .adv(rx_valid), .ok(word_ok), .bad(word_bad), .locked(locked)
  );

  err_acc #(.EW(EW), .CW(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .add_en(rx_valid && locked),
    .nerr(nerr), .count(err_count)
  );
endmodule

// File: tb/tb_prbs_verifier.sv
`timescale 1ns/1ps
module tb_prbs_verifier;
  localparam int W   = 32;
  localparam int CW  = 10;
  localparam int EW  = $clog2(W + 1);
  localparam int NPB = 128 / W;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W-1:0]   rx_data = '0;
  logic           rx_valid = 1'b0;
  logic           rx_ready;
  logic [3:0]     pat_sel = '0;
  logic           pam4_en = 1'b0;
  logic [127:0]   user_word = '0;
  logic [1:0]     user_len = '0;
  logic [1:0]     alt_run = '0;
  logic [EW-1:0]  err_thresh = EW'(8);
  logic           cnt_clr = 1'b0;
  logic           locked;
  logic [CW-1:0]  err_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0]  bh;
  int           ord_g;
  bit           pam_g;
  logic [127:0] refp;
  int           ph;

  prbs_verifier #(.W(W), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .pat_sel(pat_sel), .pam4_en(pam4_en), .user_word(user_word), .user_len(user_len),
    .alt_run(alt_run), .err_thresh(err_thresh), .cnt_clr(cnt_clr),
    .locked(locked), .err_count(err_count)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tap(input int ord, input int k);
    int t [4];
    case (ord)
      9:  t = '{9, 5, 0, 0};
      11: t = '{11, 9, 0, 0};
      13: t = '{13, 12, 2, 1};
      23: t = '{23, 18, 0, 0};
      31: t = '{31, 28, 0, 0};
      58: t = '{58, 39, 0, 0};
      default: t = '{7, 6, 0, 0};
    endcase
    return t[k];
  endfunction

  task automatic gen_word(output logic [W-1:0] w);
    logic [W-1:0] p;
    for (int i = 0; i < W; i++) begin
      logic b;
      b = bh[tap(ord_g, 0) - 1] ^ bh[tap(ord_g, 1) - 1];
      if (tap(ord_g, 2) != 0) b = b ^ bh[tap(ord_g, 2) - 1] ^ bh[tap(ord_g, 3) - 1];
      p[i] = b;
      bh = {bh[62:0], b};
    end
    w = p;
    if (pam_g) for (int k = 0; k < W / 2; k++) w[2*k+1] = p[2*k+1] ^ p[2*k];
  endtask

  function automatic logic [127:0] build_ref(input bit usr, input logic [127:0] u,
                                             input int lc, input int rc);
    logic [127:0] r;
    int len, run;
    len = (lc == 0) ? 32 : (lc == 1) ? 64 : 128;
    run = (rc == 0) ? 1 : (rc == 1) ? 8 : 64;
    for (int j = 0; j < 128; j++) r[j] = usr ? u[j % len] : logic'((j / run) % 2);
    return r;
  endfunction

  function automatic logic [W-1:0] pat_word();
    logic [W-1:0] w;
    w = refp[(ph % NPB) * W +: W];
    ph++;
    return w;
  endfunction

  function automatic logic [W-1:0] fmask(input int k);
    logic [W-1:0] m;
    int n;
    m = '0;
    n = 0;
    while (n < k) begin
      int pos;
      pos = int'($urandom % W);
      if (!m[pos]) begin m[pos] = 1'b1; n++; end
    end
    return m;
  endfunction

  task automatic send(input logic [W-1:0] d, input logic clr);
    @(negedge clk);
    rx_data = d; rx_valid = 1'b1; cnt_clr = clr;
    @(posedge clk); #1;
    rx_valid = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic idle(input int n, input logic clr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_data = $urandom; rx_valid = 1'b0; cnt_clr = clr;
      @(posedge clk); #1;
      cnt_clr = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic seed_gen(input int ord, input bit pam);
    ord_g = ord; pam_g = pam;
    bh = {$urandom, $urandom} | 64'h1;
  endtask

  task automatic send_prbs(input int n, input int flips, inout int tot);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w;
      gen_word(w);
      send(w ^ (flips > 0 ? fmask(flips) : '0), 1'b0);
      tot += flips;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dummy;
    int tot;
    int ords [7];
    void'($urandom(32'd4711));
    ords = '{7, 9, 11, 13, 23, 31, 58};
    dummy = 0;

    // R1 reset state
    @(negedge clk);
    chk("R1 locked in reset", locked, 0);
    chk("R1 count in reset", err_count, 0);
    do_reset();
    @(posedge clk); #1;
    chk("R1 locked after reset", locked, 0);
    chk("R1 count after reset", err_count, 0);
    chk("R1 ready", rx_ready, 1);

    // R2 exact lock timing, PRBS7 NRZ
    pat_sel = 4'd0; pam4_en = 1'b0; err_thresh = EW'(8);
    do_reset();
    seed_gen(7, 0);
    send_prbs(4, 0, dummy);
    chk("R2 not locked after 4 words", locked, 0);
    send_prbs(1, 0, dummy);
    chk("R2 locked after 5th word", locked, 1);

    // R10 idle cycles with garbage
    idle(3, 1'b0);
    chk("R10 lock held over idle", locked, 1);
    chk("R10 count held over idle", err_count, 0);
    send_prbs(3, 0, dummy);
    chk("R4 clean words count nothing", err_count, 0);

    // R4 single corrupted word, no multiplication
    send_prbs(1, 3, dummy);
    chk("R4 three flips counted", err_count, 3);
    send_prbs(1, 0, dummy);
    chk("R4 no error multiplication", err_count, 3);

    // R9 clear alone, then clear together with counted errors
    idle(1, 1'b1);
    chk("R9 clear alone", err_count, 0);
    begin
      logic [W-1:0] w;
      gen_word(w);
      send(w ^ fmask(5), 1'b1);
    end
    chk("R9 clear wins over errors", err_count, 0);
    send_prbs(1, 2, dummy);
    chk("R9 counting after clear", err_count, 2);

    // R5 threshold boundary and lock loss
    send_prbs(4, 8, dummy);
    chk("R5 errors equal threshold keep lock", locked, 1);
    chk("R5 count at threshold", err_count, 34);
    send_prbs(3, 9, dummy);
    chk("R5 three bad words keep lock", locked, 1);
    send_prbs(1, 9, dummy);
    chk("R5 fourth bad word drops lock", locked, 0);
    chk("R5 dropping word counted", err_count, 70);
    send_prbs(1, 3, dummy);
    chk("R4 no count while unlocked", err_count, 70);
    send_prbs(12, 0, dummy);
    chk("R5 relock after reseed", locked, 1);
    chk("R5 count after relock", err_count, 70);

    // R2 and R3: every order, both forms
    for (int o = 0; o < 7; o++) begin
      for (int pm = 0; pm < 2; pm++) begin
        pat_sel = 4'(o); pam4_en = pm[0]; err_thresh = EW'(8);
        do_reset();
        seed_gen(ords[o], pm[0]);
        send_prbs(10, 0, dummy);
        chk(pm ? "R3 PAM4 lock" : "R2 NRZ lock", locked, 1);
        tot = 0;
        for (int k = 0; k < 3; k++) send_prbs(1, 1 + int'($urandom % 6), tot);
        chk(pm ? "R3 PAM4 error count" : "R4 NRZ error count", err_count, 64'(tot));
      end
    end

    // R6 user word, each length
    for (int lc = 0; lc < 3; lc++) begin
      pat_sel = 4'd7; pam4_en = 1'b0; err_thresh = EW'(8);
      user_len = 2'(lc);
      user_word = {$urandom, $urandom, $urandom, $urandom};
      refp = build_ref(1, user_word, lc, 0);
      do_reset();
      ph = 0;
      for (int i = 0; i < 3; i++) send(pat_word(), 1'b0);
      chk("R6 not locked after 3 words", locked, 0);
      send(pat_word(), 1'b0);
      chk("R6 locked after 4 words", locked, 1);
      send(pat_word() ^ fmask(4), 1'b0);
      send(pat_word() ^ fmask(4), 1'b0);
      chk("R6 user word error count", err_count, 8);
    end

    // R7 square wave, each run, random start phase
    for (int rc = 0; rc < 3; rc++) begin
      pat_sel = 4'd8; err_thresh = EW'(8);
      alt_run = 2'(rc);
      refp = build_ref(0, '0, 0, rc);
      do_reset();
      ph = int'($urandom % NPB);
      for (int i = 0; i < 12; i++) send(pat_word(), 1'b0);
      chk("R7 square wave lock", locked, 1);
      chk("R7 no errors after lock", err_count, 0);
      send(pat_word() ^ fmask(6), 1'b0);
      chk("R7 square wave error count", err_count, 6);
    end

    // R8 saturation
    pat_sel = 4'd7; user_len = 2'd0; err_thresh = EW'(32);
    user_word = {$urandom, $urandom, $urandom, $urandom};
    refp = build_ref(1, user_word, 0, 0);
    do_reset();
    ph = 0;
    for (int i = 0; i < 4; i++) send(pat_word(), 1'b0);
    chk("R8 locked before flood", locked, 1);
    for (int i = 0; i < 31; i++) send(~pat_word(), 1'b0);
    chk("R8 count below ceiling", err_count, 992);
    send(~pat_word(), 1'b0);
    chk("R8 saturates at ceiling", err_count, 1023);
    send(~pat_word(), 1'b0);
    chk("R8 stays at ceiling", err_count, 1023);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule